// File: doc/BRIEF.md
# Fast-Lock and Resync Timer

This block times two loop-assist actions of a fractional-N synthesizer. It counts phase-detector cycles, and a write of the frequency word starts it. In fast-lock mode it holds a wide-bandwidth control high while the loop settles. That level is meant to raise the charge-pump current and to ground the loop-filter switch. In resync mode it keeps its output low for the whole delay and then emits one resynchronization pulse to the sigma-delta modulator.

The timeout is the product of two values: a programmed clock-divider value and the fractional modulus. The product is counted in phase-detector ticks. For example, a divider of 80 with a modulus of 125 at a 25 MHz phase-detector rate gives 10,000 ticks, which is 400 µs. The mode, the divider and the modulus are sampled at the moment of the write. They keep their effect until the count ends or a later write replaces them. The analog switching is outside this block.

Top module: `lat_timer`

## Requirements
- R1: The 2-bit mode is decoded as follows: 2'b01 is fast-lock, 2'b10 is resync, 2'b00 is off and 2'b11 is reserved. A write with mode 2'b00 or 2'b11 starts nothing and stops any count in progress.
- R2: In fast-lock mode, `fast_lock_o` rises in the cycle after the write. It stays high until the tick numbered divider × modulus has been counted, and it is low in the cycle after that tick's clock edge.
- R3: In resync mode, `resync_o` is high for exactly one cycle: the cycle after the edge that counts tick number divider × modulus. It is low at all other times.
- R4: A fast-lock run never produces a resync pulse, and a resync run never raises `fast_lock_o`.
- R5: A write during a count restarts the timer from the newly sampled divider, modulus and mode.
- R6: A write with a divider value of zero or a modulus of zero produces no output in either mode, and it stops any count in progress.
- R7: Only cycles with `tick_i` high advance the count. Ticks that arrive while no count is running have no effect.
- R8: After reset, both outputs are low and no count is running.
- R9: When a write and a tick arrive in the same cycle, the write takes priority and that tick is not counted.
- R10: Changes on `mode_i`, `div_i` or `mod_i` between writes have no effect on a count that is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| mode_i | input | 2 | Timer mode (encoding in R1) |
| div_i | input | DIV_W | Clock-divider value |
| mod_i | input | MOD_W | Fractional modulus |
| tick_i | input | 1 | One-cycle strobe per phase-detector cycle |
| freq_wr_i | input | 1 | Strobe marking a write of the frequency word |
| fast_lock_o | output | 1 | Wide-bandwidth control level |
| resync_o | output | 1 | One-cycle resynchronization pulse |

## Verification
The bench builds the timer with DIV_W = 5 and MOD_W = 4, so the largest divider (31) and the largest modulus (15) are both legal inputs. The full-scale product of 465 ticks then fits in a short run. At these widths, all-ones values, the single-tick product 1 × 1 and zero operands are all in reach together. The random phase can also land restarts, cancels and same-cycle write/tick collisions close to the terminal tick.

// File: rtl/lat_pkg.sv
package lat_pkg;
  typedef enum logic [1:0] {
    LAT_OFF    = 2'b00,
    LAT_FAST   = 2'b01,
    LAT_RESYNC = 2'b10,
    LAT_RSVD   = 2'b11
  } lat_mode_e;
endpackage

// File: rtl/lat_arm.sv
// Write qualification: decides whether a frequency-word write starts a run
// or cancels one.
module lat_arm #(
  parameter int DIV_W = 12,
  parameter int MOD_W = 12
) (
  input  logic [1:0]       mode_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic [MOD_W-1:0] mod_i,
  input  logic             wr_i,
  output logic             load_o,
  output logic             cancel_o
);
  import lat_pkg::*;

  logic mode_ok;
  logic operands_ok;

  always_comb begin
    mode_ok     = (mode_i == LAT_FAST) || (mode_i == LAT_RESYNC);
    operands_ok = (div_i != '0) && (mod_i != '0);
    load_o      = wr_i && mode_ok && operands_ok;
    cancel_o    = wr_i && !(mode_ok && operands_ok);
  end
endmodule

// File: rtl/lat_count.sv
// Two nested down-counters: the inner one counts modulus ticks and the
// outer one counts divider steps, so the product is never formed.
module lat_count #(
  parameter int DIV_W = 12,
  parameter int MOD_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             cancel_i,
  input  logic             tick_i,
  input  logic [1:0]       mode_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic [MOD_W-1:0] mod_i,
  output logic             run_o,
  output logic [1:0]       mode_o,
  output logic             done_o
);
  localparam logic [DIV_W-1:0] OUTER_ONE = DIV_W'(1);
  localparam logic [MOD_W-1:0] INNER_ONE = MOD_W'(1);

  logic             run_q,   run_d;
  logic [DIV_W-1:0] outer_q, outer_d;
  logic [MOD_W-1:0] inner_q, inner_d;
  logic [MOD_W-1:0] modr_q,  modr_d;
  logic [1:0]       mode_q,  mode_d;
  logic             step;
  logic             last;
  logic             en;

  always_comb begin
    step    = run_q && tick_i && !load_i && !cancel_i;
    last    = (inner_q == INNER_ONE) && (outer_q == OUTER_ONE);
    en      = load_i || cancel_i || step;
    run_d   = run_q;
    outer_d = outer_q;
    inner_d = inner_q;
    modr_d  = modr_q;
    mode_d  = mode_q;
    if (load_i) begin
      run_d   = 1'b1;
      outer_d = div_i;
      inner_d = mod_i;
      modr_d  = mod_i;
      mode_d  = mode_i;
    end else if (cancel_i) begin
      run_d = 1'b0;
    end else if (step) begin
      if (last) begin
        run_d = 1'b0;
      end else if (inner_q == INNER_ONE) begin
        outer_d = outer_q - OUTER_ONE;
        inner_d = modr_q;
      end else begin
        inner_d = inner_q - INNER_ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      outer_q <= '0;
      inner_q <= '0;
      modr_q  <= '0;
      mode_q  <= '0;
    end else if (en) begin
      run_q   <= run_d;
      outer_q <= outer_d;
      inner_q <= inner_d;
      modr_q  <= modr_d;
      mode_q  <= mode_d;
    end
  end

  assign run_o  = run_q;
  assign mode_o = mode_q;
  assign done_o = step && last;

  p_live_counts_r2: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (outer_q != '0) && (inner_q != '0));

  p_hold_no_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !tick_i && !load_i && !cancel_i) |=>
      (run_q && $stable(outer_q) && $stable(inner_q)));

  p_cancel_stops_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cancel_i |=> !run_q);

  p_load_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> run_q && (outer_q == $past(div_i)) && (inner_q == $past(mod_i)));

  p_mode_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !load_i) |=> $stable(mode_q));
endmodule

// File: rtl/lat_drive.sv
// Output stage: the fast-lock level is decoded from state, the resync
// strobe is registered.
module lat_drive (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run_i,
  input  logic [1:0] mode_i,
  input  logic       done_i,
  output logic       fast_o,
  output logic       pulse_o
);
  import lat_pkg::*;

  logic pulse_q, pulse_d;

  always_comb begin
    pulse_d = done_i && (mode_i == LAT_RESYNC);
    fast_o  = run_i && (mode_i == LAT_FAST);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse_q <= 1'b0;
    else        pulse_q <= pulse_d;
  end

  assign pulse_o = pulse_q;

  p_pulse_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |=> !pulse_q);

  p_outputs_exclusive_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(fast_o && pulse_q));

  p_pulse_ends_run_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |-> !run_i || (mode_i != LAT_FAST));
endmodule

// File: rtl/lat_timer.sv
module lat_timer #(
  parameter int DIV_W = 12,
  parameter int MOD_W = 12
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic [1:0]       mode_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic [MOD_W-1:0] mod_i,
  input  logic             tick_i,
  input  logic             freq_wr_i,
  output logic             fast_lock_o,
  output logic             resync_o
);
  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_n;
  logic                   load;
  logic                   cancel;
  logic                   run;
  logic [1:0]             mode_q;
  logic                   done;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= '0;
    else         rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_n = rst_sync_q[SYNC_STAGES-1];

  lat_arm #(.DIV_W(DIV_W), .MOD_W(MOD_W)) u_arm (
    .mode_i   (mode_i),
    .div_i    (div_i),
    .mod_i    (mod_i),
    .wr_i     (freq_wr_i),
    .load_o   (load),
    .cancel_o (cancel)
  );

  lat_count #(.DIV_W(DIV_W), .MOD_W(MOD_W)) u_count (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (load),
    .cancel_i (cancel),
    .tick_i   (tick_i),
    .mode_i   (mode_i),
    .div_i    (div_i),
    .mod_i    (mod_i),
    .run_o    (run),
    .mode_o   (mode_q),
    .done_o   (done)
  );

  lat_drive u_drive (
    .clk     (clk),
    .rst_n   (rst_n),
    .run_i   (run),
    .mode_i  (mode_q),
    .done_i  (done),
    .fast_o  (fast_lock_o),
    .pulse_o (resync_o)
  );

  p_write_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (freq_wr_i && tick_i && run) |=> !resync_o);
endmodule

// File: tb/lat_timer_tb.sv
module lat_timer_tb;
  localparam int DW = 5;
  localparam int MW = 4;

  logic          clk = 1'b0;
  logic          rst_ni;
  logic [1:0]    mode;
  logic [DW-1:0] dv;
  logic [MW-1:0] md;
  logic          tick;
  logic          wr;
  logic          fl;
  logic          rs;

  int    total = 0;
  int    bad   = 0;
  bit    finished = 1'b0;
  string tag = "R8";

  // reference state
  bit       m_run;
  bit       m_pulse;
  int       m_left;
  bit [1:0] m_mode;

  always #2 clk = ~clk;

  lat_timer #(.DIV_W(DW), .MOD_W(MW)) u_dut (
    .clk(clk), .rst_ni(rst_ni), .mode_i(mode), .div_i(dv), .mod_i(md),
    .tick_i(tick), .freq_wr_i(wr), .fast_lock_o(fl), .resync_o(rs)
  );

  function automatic bit starts(bit [1:0] m, int d, int q);
    return (m == 2'b01 || m == 2'b10) && d != 0 && q != 0;
  endfunction

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_run <= 1'b0; m_pulse <= 1'b0; m_left <= 0; m_mode <= 2'b00;
    end else if (wr) begin
      m_pulse <= 1'b0;
      if (starts(mode, int'(dv), int'(md))) begin
        m_run <= 1'b1; m_left <= int'(dv) * int'(md); m_mode <= mode;
      end else m_run <= 1'b0;
    end else if (m_run && tick) begin
      if (m_left == 1) begin
        m_run <= 1'b0; m_pulse <= (m_mode == 2'b10);
      end else begin
        m_left <= m_left - 1; m_pulse <= 1'b0;
      end
    end else m_pulse <= 1'b0;
  end

  task automatic compare();
    bit efl;
    efl = m_run && (m_mode == 2'b01);
    total++;
    if (fl !== efl || rs !== m_pulse) begin
      bad++;
      $display("FAIL %s fast_lock act=%0b exp=%0b resync act=%0b exp=%0b t=%0t",
               tag, fl, efl, rs, m_pulse, $time);
    end
  endtask

  // one cycle: check at the falling edge, then drive
  task automatic cyc(input bit w, input bit t);
    @(negedge clk);
    compare();
    wr = w; tick = t;
  endtask

  task automatic set_cfg(input bit [1:0] m, input int d, input int q);
    mode = m; dv = DW'(d); md = MW'(q);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 1'b1);
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    rst_ni = 1'b0; wr = 0; tick = 0; set_cfg(2'b00, 0, 0);
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    tag = "R8";
    repeat (4) cyc(0, 0);

    tag = "R7";                      // ticks while idle
    repeat (4) cyc(0, 1);

    tag = "R2";                      // fast-lock, 3 x 2 = 6 ticks
    set_cfg(2'b01, 3, 2); cyc(1, 0); ticks(8); cyc(0, 0);

    tag = "R3";                      // resync, 2 x 3 = 6 ticks
    set_cfg(2'b10, 2, 3); cyc(1, 0); ticks(8); cyc(0, 0);

    tag = "R3";                      // single-tick product
    set_cfg(2'b10, 1, 1); cyc(1, 0); ticks(3);

    tag = "R7";                      // gaps without ticks
    set_cfg(2'b01, 2, 2); cyc(1, 0);
    for (int i = 0; i < 12; i++) cyc(0, i[0]);

    tag = "R4";                      // fast-lock run never pulses
    set_cfg(2'b01, 1, 3); cyc(1, 0); ticks(5);
    tag = "R4";                      // resync run never raises level
    set_cfg(2'b10, 1, 3); cyc(1, 0); ticks(5);

    tag = "R5";                      // restart mid-count
    set_cfg(2'b10, 2, 2); cyc(1, 0); ticks(3);
    set_cfg(2'b10, 3, 1); cyc(1, 0); ticks(5);

    tag = "R9";                      // write with tick in same cycle
    set_cfg(2'b01, 1, 2); cyc(1, 0); cyc(0, 1);
    set_cfg(2'b01, 1, 2); cyc(1, 1); ticks(4);

    tag = "R6";                      // zero divider cancels
    set_cfg(2'b01, 4, 4); cyc(1, 0); ticks(2);
    set_cfg(2'b01, 0, 4); cyc(1, 0); ticks(20);
    tag = "R6";                      // zero modulus
    set_cfg(2'b10, 3, 0); cyc(1, 0); ticks(6);

    tag = "R1";                      // reserved and off modes
    set_cfg(2'b10, 3, 3); cyc(1, 0); ticks(2);
    set_cfg(2'b11, 3, 3); cyc(1, 0); ticks(12);
    set_cfg(2'b01, 3, 3); cyc(1, 0); ticks(2);
    set_cfg(2'b00, 3, 3); cyc(1, 0); ticks(12);

    tag = "R10";                     // inputs move during a run
    set_cfg(2'b01, 2, 3); cyc(1, 0);
    set_cfg(2'b10, 1, 1); ticks(8);

    tag = "R3";                      // full-scale product 31 x 15
    set_cfg(2'b10, 31, 15); cyc(1, 0); ticks(470);
    tag = "R2";
    set_cfg(2'b01, 31, 15); cyc(1, 0); ticks(470);

    tag = "R5";                      // random mix
    for (int i = 0; i < 4000; i++) begin
      bit w;
      w = ($urandom_range(0, 39) == 0);
      if (w) set_cfg(2'($urandom_range(0, 3)), $urandom_range(0, 5),
                     $urandom_range(0, 4));
      else if ($urandom_range(0, 7) == 0)
        set_cfg(2'($urandom_range(0, 3)), $urandom_range(0, 31),
                $urandom_range(0, 15));
      cyc(w, $urandom_range(0, 1) == 1);
    end
    cyc(0, 0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule